// File: doc/BRIEF.md
# Predicate Test Flag Generator

This block derives four condition flags from two predicates: a result predicate and a governing predicate that marks the active lanes. Both are delivered one 64-bit word per accepted cycle, lowest word first. The first word of a predicate carries a start strobe and the final word carries a last strobe. One cycle after the final word is accepted, the block raises a single-cycle `flags_valid` pulse. The flags it presents are as follows:

- negative: the result bit at the first active lane.
- zero: set when no active lane holds a one.
- carry: the inverse of the result bit at the last active lane.
- overflow: always zero.

An optional find-first mode is selected together with the start word. In that mode the lowest active lane of the first word that has any active lane is forced to one in the result predicate before the flags are evaluated. Every updated result word is streamed back out one cycle after it is accepted, so the caller can write it back. Element-size masking is the caller's job, and so is predicate storage. The governing words arrive already masked.

Top module: `pred_flag_gen`

## Requirements
- R1: After reset `flags_valid` and `dout_valid` are 0, and the flag outputs read negative=0, zero=1, carry=1, overflow=0.
- R2: A word whose governing bits are all zero leaves the accumulated state unchanged. A predicate with no governing bit set anywhere yields negative=0, zero=1, carry=1.
- R3: Negative equals the result bit at the lowest set governing bit of the first word that has any governing bit set. Later words cannot change it.
- R4: Zero is 1 exactly when no accepted word of the predicate has a bit set in both the result and the governing word.
- R5: Carry is 1 when the result bit is 0 at the highest set governing bit of the last word that has any governing bit set.
- R6: Overflow is always 0.
- R7: A word is taken only in a cycle with `word_valid` high; in other cycles every other input is ignored. `flags_valid` pulses for exactly one cycle, one cycle after the word with `word_last` is taken. The flag outputs hold their value until the next last word.
- R8: A word taken with `word_start` high discards all state from earlier predicates.
- R9: `find_first` is sampled only with the start word. In find-first mode, bit (lowest set governing bit) of the first word with any governing bit is ORed into the result before that word's flags are evaluated. Each taken word then appears on `dout_word` with `dout_valid` high one cycle after it is taken, and all other words pass through unchanged.
- R10: In normal mode `dout_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | A predicate word is offered this cycle |
| word_start | input | 1 | Offered word is the first of a predicate |
| word_last | input | 1 | Offered word is the last of a predicate |
| find_first | input | 1 | Find-first mode, sampled with the start word |
| d_word | input | 64 | Result predicate word |
| g_word | input | 64 | Governing predicate word, pre-masked |
| dout_valid | output | 1 | Updated result word is present (find-first mode) |
| dout_word | output | 64 | Updated result word |
| flags_valid | output | 1 | One-cycle pulse: flags are fresh |
| flag_n | output | 1 | Negative: first active lane |
| flag_z | output | 1 | Zero: no active lane set |
| flag_c | output | 1 | Carry: last active lane clear |
| flag_v | output | 1 | Overflow, constant zero |

## Verification
The updated result word for a given input word is due exactly one cycle after it is taken. The flags and their `flags_valid` pulse are due one cycle after the last word, and the pulse must be gone one cycle later. The bench drives inputs on the falling edge and reads each output at the next falling edge after the capturing rising edge, which is exactly when each result is due. Idle cycles inserted between words carry random data and stray strobes, and each one is followed by a check that nothing was streamed. Expected flags come from a lane-by-lane serial model run across all words.

// File: rtl/pred_flag_pkg.sv
// Shared types for the predicate flag generator.
package pred_flag_pkg;
    // Accumulated state carried from one predicate word to the next.
    typedef struct packed {
        logic n;     // result bit at first active lane
        logic any;   // some active lane held a one
        logic c;     // inverse of result bit at last active lane
        logic seen;  // an active lane has already been met
    } acc_t;

    localparam acc_t ACC_INIT = '{n: 1'b0, any: 1'b0, c: 1'b1, seen: 1'b0};
endpackage

// File: rtl/pred_bit_iso.sv
// Isolates the lowest and the highest set bit of a word.
// Assumes nothing about the input; an all-zero word gives zero on both outputs.
module pred_bit_iso #(
    parameter int W = 64
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] low_bit,
    output logic [W-1:0] high_bit
);
    // Lowest set bit via two's complement.
    assign low_bit = vec & (~vec + W'(1));

    // Highest set bit: keep a bit only if no bit above it is set.
    always_comb begin
        logic above;
        above    = 1'b0;
        high_bit = '0;
        for (int i = W - 1; i >= 0; i--) begin
            high_bit[i] = vec[i] & ~above;
            above       = above | vec[i];
        end
    end
endmodule

// File: rtl/pred_word_eval.sv
// Evaluates one predicate word against the incoming accumulated state.
// Applies the find-first update when this is the first word with active lanes.
// Purely combinational; the caller registers acc_out.
module pred_word_eval
    import pred_flag_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] d_in,
    input  logic [W-1:0] g_in,
    input  logic         ff_mode,
    input  acc_t         acc_in,
    output acc_t         acc_out,
    output logic [W-1:0] d_upd
);
    logic [W-1:0] g_low;
    logic [W-1:0] g_high;

    pred_bit_iso #(.W(W)) u_iso (
        .vec     (g_in),
        .low_bit (g_low),
        .high_bit(g_high)
    );

    // Fold this word into the state; words with no active lane pass it through.
    always_comb begin
        d_upd   = d_in;
        acc_out = acc_in;
        if (|g_in) begin
            if (!acc_in.seen) begin
                if (ff_mode) begin
                    d_upd = d_in | g_low;
                end
                acc_out.n    = |(d_upd & g_low);
                acc_out.seen = 1'b1;
            end
            acc_out.any = acc_in.any | (|(d_upd & g_in));
            acc_out.c   = ~|(d_upd & g_high);
        end
    end
endmodule

// File: rtl/pred_flag_acc.sv
// State, flag and stream registers of the predicate flag generator.
// Assumes acc_next and d_upd were computed from the word offered this cycle.
module pred_flag_acc
    import pred_flag_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         word_valid,
    input  logic         word_last,
    input  logic         ff_eff,
    input  acc_t         acc_next,
    input  logic [W-1:0] d_upd,
    output acc_t         acc_q,
    output logic         mode_q,
    output logic         flags_valid,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         dout_valid,
    output logic [W-1:0] dout_word
);
    // Accumulated state and latched mode advance on each taken word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= ACC_INIT;
            mode_q <= 1'b0;
        end else if (word_valid) begin
            acc_q  <= acc_next;
            mode_q <= ff_eff;
        end
    end

    // Flags are captured from the last word and held until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_valid <= 1'b0;
            flag_n      <= 1'b0;
            flag_z      <= 1'b1;
            flag_c      <= 1'b1;
        end else begin
            flags_valid <= word_valid & word_last;
            if (word_valid && word_last) begin
                flag_n <= acc_next.n;
                flag_z <= ~acc_next.any;
                flag_c <= acc_next.c;
            end
        end
    end

    // Updated result words are streamed out in find-first mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_valid <= 1'b0;
            dout_word  <= '0;
        end else begin
            dout_valid <= word_valid & ff_eff;
            if (word_valid) begin
                dout_word <= d_upd;
            end
        end
    end

    a_r7_flags_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flags_valid |-> $past(word_valid && word_last));
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flags_valid |=> !flags_valid || $past(word_valid && word_last));
endmodule

// File: rtl/pred_flag_gen.sv
// Predicate test flag generator (top).
// Streams result and governing predicate words, lowest first, and produces
// negative/zero/carry/overflow one cycle after the last word. Optional
// find-first mode sets the first active lane in the result and streams it back.
// Assumes governing words are already masked to the element size.
module pred_flag_gen
    import pred_flag_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic              word_start,
    input  logic              word_last,
    input  logic              find_first,
    input  logic [WORD_W-1:0] d_word,
    input  logic [WORD_W-1:0] g_word,
    output logic              dout_valid,
    output logic [WORD_W-1:0] dout_word,
    output logic              flags_valid,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);
    acc_t              acc_q;
    acc_t              acc_in;
    acc_t              acc_next;
    logic              mode_q;
    logic              ff_eff;
    logic [WORD_W-1:0] d_upd;

    // A start word restarts from the initial state and samples the mode.
    assign acc_in = word_start ? ACC_INIT : acc_q;
    assign ff_eff = word_start ? find_first : mode_q;
    assign flag_v = 1'b0;

    pred_word_eval #(.W(WORD_W)) u_eval (
        .d_in   (d_word),
        .g_in   (g_word),
        .ff_mode(ff_eff),
        .acc_in (acc_in),
        .acc_out(acc_next),
        .d_upd  (d_upd)
    );

    pred_flag_acc #(.W(WORD_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_last  (word_last),
        .ff_eff     (ff_eff),
        .acc_next   (acc_next),
        .d_upd      (d_upd),
        .acc_q      (acc_q),
        .mode_q     (mode_q),
        .flags_valid(flags_valid),
        .flag_n     (flag_n),
        .flag_z     (flag_z),
        .flag_c     (flag_c),
        .dout_valid (dout_valid),
        .dout_word  (dout_word)
    );

    a_r2_idle_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_start && g_word == '0) |=> acc_q == $past(acc_q));
    a_r3_n_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_start && acc_q.seen) |=> acc_q.n == $past(acc_q.n));
    a_r4_any_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_start && acc_q.any) |=> acc_q.any);
    a_r9_dout_superset: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> (((dout_word & $past(d_word)) == $past(d_word))
                        && ($countones(dout_word ^ $past(d_word)) <= 1)));
    a_r10_stream_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> $past(word_valid));
endmodule

// File: tb/tb_pred_flag_gen.sv
module tb_pred_flag_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        word_valid, word_start, word_last, find_first;
    logic [63:0] d_word, g_word;
    logic        dout_valid, flags_valid, flag_n, flag_z, flag_c, flag_v;
    logic [63:0] dout_word;

    int errors = 0;
    int checks = 0;

    logic [63:0] dq [4];
    logic [63:0] gq [4];
    logic [63:0] exp_d [4];
    logic        exp_n, exp_z, exp_c;

    always #2.5 clk = ~clk;

    pred_flag_gen dut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_start(word_start),
        .word_last(word_last), .find_first(find_first), .d_word(d_word), .g_word(g_word),
        .dout_valid(dout_valid), .dout_word(dout_word), .flags_valid(flags_valid),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lane-by-lane serial model over all words.
    function automatic void ref_model(int n, bit ff);
        bit seen = 0;
        bit any = 0;
        exp_n = 0;
        exp_c = 1;
        for (int k = 0; k < n; k++) begin
            exp_d[k] = dq[k];
            for (int b = 0; b < 64; b++) begin
                if (gq[k][b]) begin
                    if (!seen) begin
                        if (ff) exp_d[k][b] = 1'b1;
                        exp_n = exp_d[k][b];
                        seen  = 1;
                    end
                    any   = any | exp_d[k][b];
                    exp_c = ~exp_d[k][b];
                end
            end
        end
        exp_z = ~any;
    endfunction

    task automatic idle_inputs();
        word_valid = 0;
        word_start = 1'($urandom);
        word_last  = 1'($urandom);
        find_first = 1'($urandom);
        d_word     = {$urandom, $urandom};
        g_word     = {$urandom, $urandom};
    endtask

    task automatic run_seq(int n, bit ff, bit gaps, string tag);
        ref_model(n, ff);
        for (int k = 0; k < n; k++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                idle_inputs();
                @(negedge clk);
                chk("R7 idle cycle streams nothing", 64'(dout_valid), 64'd0);
            end
            word_valid = 1;
            word_start = (k == 0);
            word_last  = (k == n - 1);
            find_first = (k == 0) ? ff : 1'($urandom);
            d_word     = dq[k];
            g_word     = gq[k];
            @(negedge clk);
            if (ff) begin
                chk("R9 dout_valid", 64'(dout_valid), 64'd1);
                chk("R9 dout_word", dout_word, exp_d[k]);
            end else begin
                chk("R10 dout_valid low", 64'(dout_valid), 64'd0);
            end
            if (k < n - 1) chk("R7 no early flags_valid", 64'(flags_valid), 64'd0);
        end
        idle_inputs();
        chk("R7 flags_valid pulse", 64'(flags_valid), 64'd1);
        chk({"R3 N ", tag}, 64'(flag_n), 64'(exp_n));
        chk({"R4 Z ", tag}, 64'(flag_z), 64'(exp_z));
        chk({"R5 C ", tag}, 64'(flag_c), 64'(exp_c));
        chk("R6 V", 64'(flag_v), 64'd0);
        @(negedge clk);
        chk("R7 pulse ends", 64'(flags_valid), 64'd0);
        chk("R7 N held", 64'(flag_n), 64'(exp_n));
        chk("R7 C held", 64'(flag_c), 64'(exp_c));
    endtask

    function automatic logic [63:0] rand_g();
        case ($urandom % 5)
            0: return 64'd0;
            1: return 64'd1 << ($urandom % 64);
            2: return {$urandom, $urandom};
            3: return {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            default: return '1;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 0;
        idle_inputs();
        word_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 flags_valid", 64'(flags_valid), 64'd0);
        chk("R1 dout_valid", 64'(dout_valid), 64'd0);
        chk("R1 N", 64'(flag_n), 64'd0);
        chk("R1 Z", 64'(flag_z), 64'd1);
        chk("R1 C", 64'(flag_c), 64'd1);
        chk("R1 V", 64'(flag_v), 64'd0);

        // R8 setup: everything active and set.
        for (int k = 0; k < 4; k++) begin dq[k] = '1; gq[k] = '1; end
        run_seq(4, 0, 0, "all set");
        // R2 and R8: no governing bit anywhere after a busy predicate.
        for (int k = 0; k < 3; k++) begin dq[k] = '1; gq[k] = '0; end
        run_seq(3, 0, 0, "R2 R8 all-zero G");
        chk("R2 N zero", 64'(flag_n), 64'd0);
        chk("R8 Z cleared", 64'(flag_z), 64'd1);
        // R3: N locked by first active word.
        dq[0] = 64'h20; gq[0] = 64'h20; dq[1] = '0; gq[1] = '1;
        run_seq(2, 0, 0, "N lock");
        chk("R3 N locked", 64'(flag_n), 64'd1);
        // R5: single active lane at the top of word 3.
        for (int k = 0; k < 4; k++) begin dq[k] = '1; gq[k] = '0; end
        gq[3] = 64'h8000_0000_0000_0000;
        run_seq(4, 1, 0, "top lane");
        // R9: find-first on empty result.
        dq[0] = '0; gq[0] = '0; dq[1] = '0; gq[1] = 64'h0F00; dq[2] = '0; gq[2] = 64'h1;
        run_seq(3, 1, 0, "R9 empty d");
        chk("R9 N set by find-first", 64'(flag_n), 64'd1);

        for (int t = 0; t < 300; t++) begin
            int n = 1 + ($urandom % 4);
            for (int k = 0; k < 4; k++) begin
                gq[k] = rand_g();
                case ($urandom % 4)
                    0: dq[k] = '0;
                    1: dq[k] = '1;
                    default: dq[k] = {$urandom, $urandom};
                endcase
            end
            run_seq(n, 1'($urandom), 1, "random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule